// File: doc/BRIEF.md
# Quick Reselection Bus Arbiter

This block decides bus ownership for one device on a shared parallel bus with up to 16 IDs. It watches two bus events: a bus-free indication and a disconnect pulse from the current owner. It also sees a request vector from the competing IDs and the local device's own request. The local device is modelled as the request bit at the compile-time ID `OWN_ID`. When the local device has a negotiated fast-reselection enable, the next arbitration can start at the owner's disconnect, so the bus-free interval is skipped. Without that enable, or when no quick-capable device is requesting, the block waits for bus free and runs a normal arbitration.

A per-ID capability mask marks which devices take part in quick arbitration. Devices without that capability compete only in normal arbitrations, so they keep working on the same bus. A served-ID record gives fairness inside quick rounds. Every arbitration takes a fixed `ARB_DELAY` cycles from its trigger to the grant. The grant then stays asserted until the owner's disconnect.

The state machine has five states:
- `ST_IDLE` is the bus-free wait.
- `ST_NARB` is normal arbitration.
- `ST_QARB` is quick arbitration.
- `ST_GRANT` means the bus is owned.
- `ST_WAIT_FREE` means the block has seen a disconnect and is waiting for bus free.

Its transitions are:
- IDLE→NARB on bus free with a request.
- NARB/QARB→GRANT when the delay count expires.
- GRANT→QARB on a disconnect when quick mode is enabled and a quick candidate exists.
- GRANT→WAIT_FREE on any other disconnect.
- WAIT_FREE→NARB on bus free with a request.
- WAIT_FREE→IDLE on bus free with no request.

Top module: `quick_resel_arbiter`

## Requirements
- R1: In a normal arbitration the winner is the highest-numbered requesting ID. Request bit i of `req_ids` stands for ID i, and `local_req` stands for ID `OWN_ID`.
- R2: The grant rises exactly `ARB_DELAY` clock edges after the edge that samples the trigger. It stays high with a stable `win_id` until `disc` is sampled, and it is low on the following cycle.
- R3: When `quick_en` is 1 and a quick candidate is requesting, a `disc` during grant starts a quick arbitration at once, with no bus-free event. The winner is the highest-numbered eligible ID.
- R4: When `quick_en` is 0, a `disc` leads to no grant until `bus_free` is sampled. A normal arbitration follows.
- R5: Only IDs whose `qcap` bit is 1 take part in quick arbitration. An ID with `qcap` 0 wins only through a normal arbitration after bus free, even if it is the highest requester.
- R6: An ID that won a quick arbitration is skipped in later quick arbitrations while other quick-capable requesters remain unserved. When all requesting candidates have been served, the record restarts and the highest candidate wins again.
- R7: A normal arbitration clears the served record, so every candidate is eligible at the next quick arbitration.
- R8: If no quick candidate is requesting at a disconnect, the block waits for bus free and then arbitrates normally.
- R9: `local_grant` is 1 exactly when the grant is high and `win_id` equals `OWN_ID`.
- R10: After reset, `grant`, `local_grant` and `win_id` are 0.
- R11: A bus-free event with no request present starts no arbitration, and the grant stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_free | input | 1 | Bus-free phase observed |
| disc | input | 1 | Disconnect pulse from the current owner |
| quick_en | input | 1 | Negotiated quick-arbitration enable |
| req_ids | input | NUM_IDS | Requests from competing IDs, bit i = ID i |
| qcap | input | NUM_IDS | Quick-arbitration capability per ID |
| local_req | input | 1 | Request of the local device (ID OWN_ID) |
| grant | output | 1 | Bus granted to `win_id` |
| win_id | output | $clog2(NUM_IDS) | Winning ID |
| local_grant | output | 1 | Local device owns the bus |

## Verification
The bench builds the block with `NUM_IDS` = 8, `OWN_ID` = 2 and `ARB_DELAY` = 3. The shorter delay differs from the default, so the grant timing is checked against the parameter rather than a fixed count of four. The eight IDs are enough to mix quick-capable and legacy requesters, including a legacy ID that outranks every capable one. They also allow a full fairness round over three candidates, the round reset, and the record clear after a normal arbitration.

// File: rtl/qra_pkg.sv
package qra_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NARB,
        ST_QARB,
        ST_GRANT,
        ST_WAIT_FREE
    } qra_state_e;
endpackage

// File: rtl/qra_prio_enc.sv
module qra_prio_enc #(
    parameter int N = 16,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] vec,
    output logic [W-1:0] idx,
    output logic         any
);
    logic [N-1:0][W-1:0] chain;

    // Walk upwards: a higher set bit overrides any lower result.
    for (genvar g = 0; g < N; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign chain[g] = '0;
        end else begin : g_rest
            assign chain[g] = vec[g] ? W'(g) : chain[g-1];
        end
    end

    assign idx = chain[N-1];
    assign any = |vec;
endmodule

// File: rtl/qra_fair_track.sv
module qra_fair_track #(
    parameter int N = 16,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cand,
    input  logic         clr,
    input  logic         take,
    input  logic [W-1:0] take_id,
    output logic [N-1:0] elig
);
    logic [N-1:0] served_q;
    logic [N-1:0] unserved;
    logic         round_done;

    assign unserved   = cand & ~served_q;
    assign round_done = (unserved == '0);
    assign elig       = round_done ? cand : unserved;

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                served_q[g] <= 1'b0;
            end else if (clr) begin
                served_q[g] <= 1'b0;
            end else if (take) begin
                served_q[g] <= (take_id == W'(g)) ? 1'b1
                             : (round_done ? 1'b0 : served_q[g]);
            end
        end
    end
endmodule

// File: rtl/quick_resel_arbiter.sv
module quick_resel_arbiter
    import qra_pkg::*;
#(
    parameter int NUM_IDS   = 16,
    parameter int OWN_ID    = 7,
    parameter int ARB_DELAY = 4,
    localparam int ID_W  = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1,
    localparam int CNT_W = $clog2(ARB_DELAY + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_free,
    input  logic               disc,
    input  logic               quick_en,
    input  logic [NUM_IDS-1:0] req_ids,
    input  logic [NUM_IDS-1:0] qcap,
    input  logic               local_req,
    output logic               grant,
    output logic [ID_W-1:0]    win_id,
    output logic               local_grant
);
    qra_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [ID_W-1:0]  win_q;

    logic [NUM_IDS-1:0] own_bit, all_req, qcand, elig;
    logic [ID_W-1:0]    n_id, q_id;
    logic               n_any, q_any;
    logic               start_norm, start_quick;
    logic               arb_start, arb_quick;

    assign own_bit = NUM_IDS'(local_req) << OWN_ID;
    assign all_req = req_ids | own_bit;
    assign qcand   = all_req & qcap;

    qra_prio_enc #(.N(NUM_IDS)) u_norm_enc (
        .vec (all_req),
        .idx (n_id),
        .any (n_any)
    );

    qra_fair_track #(.N(NUM_IDS)) u_fair (
        .clk     (clk),
        .rst_n   (rst_n),
        .cand    (qcand),
        .clr     (start_norm),
        .take    (start_quick),
        .take_id (q_id),
        .elig    (elig)
    );

    qra_prio_enc #(.N(NUM_IDS)) u_quick_enc (
        .vec (elig),
        .idx (q_id),
        .any (q_any)
    );

    assign start_norm  = bus_free && n_any &&
                         (state_q == ST_IDLE || state_q == ST_WAIT_FREE);
    assign start_quick = (state_q == ST_GRANT) && disc && quick_en && q_any;
    assign arb_start   = start_norm || start_quick;
    assign arb_quick   = start_quick;

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start_norm) state_d = ST_NARB;
            ST_NARB,
            ST_QARB:      if (cnt_q == CNT_W'(ARB_DELAY - 1)) state_d = ST_GRANT;
            ST_GRANT:     if (disc) state_d = start_quick ? ST_QARB : ST_WAIT_FREE;
            ST_WAIT_FREE: if (bus_free) state_d = n_any ? ST_NARB : ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register, delay counter and captured winner
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            win_q   <= '0;
        end else begin
            state_q <= state_d;
            if (arb_start) begin
                cnt_q <= '0;
                win_q <= start_quick ? q_id : n_id;
            end else if (state_q == ST_NARB || state_q == ST_QARB) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        grant       = (state_q == ST_GRANT);
        win_id      = win_q;
        local_grant = grant && (win_q == ID_W'(OWN_ID));
    end
endmodule

// File: rtl/qra_checker.sv
module qra_checker #(
    parameter int NUM_IDS   = 16,
    parameter int OWN_ID    = 7,
    parameter int ARB_DELAY = 4,
    localparam int ID_W = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1,
    localparam int CW   = $clog2(ARB_DELAY + 2) + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_free,
    input logic               disc,
    input logic               quick_en,
    input logic [NUM_IDS-1:0] qcap,
    input logic               grant,
    input logic [ID_W-1:0]    win_id,
    input logic               local_grant,
    input logic               arb_start,
    input logic               arb_quick
);
    logic [CW-1:0] since_q;
    logic          quick_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
            quick_q <= 1'b0;
        end else begin
            if (arb_start) begin
                since_q <= CW'(1);
                quick_q <= arb_quick;
            end else if (since_q != '0 && since_q <= CW'(ARB_DELAY)) begin
                since_q <= since_q + 1'b1;
            end else begin
                since_q <= '0;
            end
        end
    end

    AST_NO_EARLY_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q != '0 && since_q <= CW'(ARB_DELAY)) |-> !grant); // R2
    AST_GRANT_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q == CW'(ARB_DELAY + 1)) |-> grant); // R2
    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !disc) |=> (grant && $stable(win_id))); // R2
    AST_DISC_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && disc) |=> !grant); // R2
    AST_QUICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_start && arb_quick) |-> (quick_en && disc)); // R3
    AST_LEGACY_AFTER_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_start && !arb_quick) |-> bus_free); // R4
    AST_QUICK_CAPABLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(grant) && quick_q) |-> qcap[win_id]); // R5
    AST_LOCAL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        local_grant |-> (grant && win_id == ID_W'(OWN_ID))); // R9
endmodule

bind quick_resel_arbiter qra_checker #(
    .NUM_IDS   (NUM_IDS),
    .OWN_ID    (OWN_ID),
    .ARB_DELAY (ARB_DELAY)
) u_qra_checker (.*);

// File: tb/test_quick_resel_arbiter.sv
module test_quick_resel_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 8;
    localparam int OWN = 2;
    localparam int DLY = 3;
    localparam int IW  = $clog2(N);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_free = 1'b0, disc = 1'b0, quick_en = 1'b0, local_req = 1'b0;
    logic [N-1:0] req_ids = '0, qcap = '0;
    logic         grant, local_grant;
    logic [IW-1:0] win_id;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;
    int exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    quick_resel_arbiter #(.NUM_IDS(N), .OWN_ID(OWN), .ARB_DELAY(DLY)) i_quick_resel_arbiter (
        .clk(clk), .rst_n(rst_n), .bus_free(bus_free), .disc(disc),
        .quick_en(quick_en), .req_ids(req_ids), .qcap(qcap), .local_req(local_req),
        .grant(grant), .win_id(win_id), .local_grant(local_grant)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: pops the expected winner on each rising grant
    initial begin
        logic prev = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && grant && !prev) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R1 unexpected grant", win_id, -1);
                end else begin
                    automatic int e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    chk(win_id == IW'(e), t, win_id, e);
                end
            end
            prev = grant;
        end
    end

    // Driver: pulse a trigger, push the expected winner, check grant timing
    task automatic arb(input bit quick, input int exp_id, input string tag);
        exp_q.push_back(exp_id);
        tag_q.push_back(tag);
        @(negedge clk);
        if (quick) disc = 1'b1; else bus_free = 1'b1;
        @(posedge clk);
        @(negedge clk);
        disc = 1'b0; bus_free = 1'b0;
        repeat (DLY - 1) @(posedge clk);
        @(negedge clk);
        chk(grant == 1'b0, "R2 grant before delay", grant, 0);
        @(posedge clk);
        @(negedge clk);
        chk(grant == 1'b1, "R2 grant at delay", grant, 1);
    endtask

    task automatic pulse_disc();
        @(negedge clk);
        disc = 1'b1;
        @(negedge clk);
        disc = 1'b0;
        chk(grant == 1'b0, "R2 release on disc", grant, 0);
    endtask

    task automatic idle_no_grant(input int cycles, input string tag);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            chk(grant == 1'b0, tag, grant, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(grant == 1'b0 && local_grant == 1'b0 && win_id == '0, "R10 reset outputs", grant, 0);
        rst_n = 1'b1;

        // R11: bus free with no requests
        @(negedge clk); bus_free = 1'b1;
        @(negedge clk); bus_free = 1'b0;
        idle_no_grant(DLY + 3, "R11 no arbitration without requests");

        // R1: highest requester wins
        req_ids = 8'b0001_0010;
        arb(1'b0, 4, "R1 normal winner of {1,4}");
        repeat (4) @(negedge clk);
        chk(grant && win_id == 3'd4, "R2 grant held", grant, 1);

        // R4: no quick when disabled
        pulse_disc();
        idle_no_grant(8, "R4 wait for bus free when quick off");
        req_ids = 8'b0000_0010; local_req = 1'b1;
        arb(1'b0, OWN, "R1 local request wins");
        chk(local_grant == 1'b1, "R9 local grant", local_grant, 1);

        // R3/R5/R6: quick rounds, ID 6 is legacy
        local_req = 1'b0;
        quick_en = 1'b1;
        qcap = 8'b0010_1010;
        req_ids = 8'b0110_1010;
        arb(1'b1, 5, "R3 quick winner skips legacy R5");
        chk(local_grant == 1'b0, "R9 no local grant", local_grant, 0);
        arb(1'b1, 3, "R6 served ID 5 skipped");
        arb(1'b1, 1, "R6 served 5,3 skipped");
        arb(1'b1, 5, "R6 round restarts");

        // R7: normal arbitration clears the record
        quick_en = 1'b0;
        pulse_disc();
        arb(1'b0, 6, "R5 legacy wins normal arbitration");
        quick_en = 1'b1;
        arb(1'b1, 5, "R7 record cleared by normal arbitration");

        // R8: only a legacy requester at disconnect
        req_ids = 8'b0100_0000;
        pulse_disc();
        idle_no_grant(8, "R8 no quick candidate waits for bus free");
        arb(1'b0, 6, "R8 normal after bus free");

        // R11 again: no requests at disconnect and bus free
        req_ids = '0;
        pulse_disc();
        @(negedge clk); bus_free = 1'b1;
        @(negedge clk); bus_free = 1'b0;
        idle_no_grant(DLY + 3, "R11 bus free without requests");

        chk(exp_q.size() == 0, "R1 all expected grants seen", exp_q.size(), 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule